// File: doc/BRIEF.md
# Processor Clock, Ready and Reset Generator

This block turns a fast oscillator into the clock set of a small 8-bit-bus processor. A divide-by-three counter in the oscillator domain produces an asymmetric processor clock that is high for one oscillator period and low for two. A peripheral clock at half the processor-clock rate is derived from it, and a buffered copy of the oscillator is passed straight out.

The same unit conditions two control signals for the processor. READY is formed from any number of request pairs, two by default. Each pair has a ready input and an active-low enable that qualifies it. The combined request passes through a two-stage synchroniser that advances only on processor-clock rising edges, so slow memory, I/O or DMA cycles can stretch the bus cycle with wait states. An active-low reset request is synchronised the same way into an active-high RESET. A synchronous, active-high power-on input `por` initialises the divider and the synchronisers.

Top module: `cgen_top`

## Requirements
- R1: The processor clock `cpu_clk` repeats every three oscillator cycles.
- R2: Within each period, `cpu_clk` is high for exactly one oscillator cycle and low for the following two.
- R3: While `por` is high, `cpu_clk`=1, `per_clk`=0, `ready`=0 and `rst_out`=1. On the first oscillator edge after `por` falls, `cpu_clk` goes low, and it rises again on the third edge.
- R4: `osc_out` follows `osc_clk` level for level.
- R5: `per_clk` toggles on every rising edge of `cpu_clk` and at no other time, which gives half the processor-clock rate at a 50% duty cycle.
- R6: Pair i is qualified when `rdy_en_n[i]`=0. The combined request is 1 when at least one qualified pair has `rdy_in[i]`=1, and 0 otherwise (a wait state).
- R7: A change of the combined request made just after a `cpu_clk` rising edge does not show on `ready` at the next rising edge. It shows at the rising edge after that, and `ready` changes only on `cpu_clk` rising edges.
- R8: `rst_out` = 1 two `cpu_clk` rising edges after `rst_req_n` is driven low, and it falls two rising edges after `rst_req_n` returns high. It changes only on `cpu_clk` rising edges.
- R9: With every enable deasserted (`rdy_en_n` all ones), `ready` is 0 whatever the ready inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator input clock |
| por | input | 1 | Synchronous active-high power-on initialise |
| rdy_in | input | NUM_PAIRS | Ready inputs, one per request pair |
| rdy_en_n | input | NUM_PAIRS | Active-low enables that qualify each ready input |
| rst_req_n | input | 1 | Active-low raw reset request |
| cpu_clk | output | 1 | Processor clock, oscillator / 3, 1/3 duty |
| osc_out | output | 1 | Buffered oscillator clock |
| per_clk | output | 1 | Peripheral clock, processor clock / 2 |
| ready | output | 1 | Synchronised READY to the processor |
| rst_out | output | 1 | Synchronised active-high RESET |

## Verification
The bench walks every interesting qualification pattern: a ready input whose enable is off, both enables off, and both pairs on at once. A qualifier with the wrong polarity, or an AND of the pairs in place of an OR, shows up as a wrong `ready` level. It samples `ready` and `rst_out` one processor edge after each change and expects the old value there. A synchroniser that is one stage short, or that is clocked from the oscillator and not from the processor-clock edge, would already show the new value. The oscillator-cycle pattern of `cpu_clk` right after power-on is checked cycle by cycle. A divider that counts to four, starts in the wrong phase or inverts the duty cycle breaks that sequence. `per_clk` is checked for alternation across processor edges.

// File: rtl/cgen_pkg.sv
package cgen_pkg;

    // Divider phases; the processor clock is high only in PH_HIGH.
    typedef enum logic [1:0] {
        PH_HIGH  = 2'd0,
        PH_LOW_A = 2'd1,
        PH_LOW_B = 2'd2
    } phase_e;

    localparam int PHASES = 3;

    // One ready request pair: ready level and its active-low enable.
    typedef struct packed {
        logic rdy;
        logic en_n;
    } rdy_pair_t;

    // Outputs of the clock section.
    typedef struct packed {
        logic cpu;
        logic rise_en;
    } cpu_clk_t;

    function automatic phase_e phase_step(input phase_e p);
        phase_e n;
        case (p)
            PH_HIGH:  n = PH_LOW_A;
            PH_LOW_A: n = PH_LOW_B;
            default:  n = PH_HIGH;
        endcase
        return n;
    endfunction

    function automatic logic pair_grants(input rdy_pair_t p);
        return p.rdy & ~p.en_n;
    endfunction

endpackage

// File: rtl/cgen_div3.sv
module cgen_div3
    import cgen_pkg::*;
(
    input  logic     osc_clk,
    input  logic     por,
    output cpu_clk_t clk_o
);
    phase_e phase_q;
    logic   cpu_q;

    always_ff @(posedge osc_clk) begin
        if (por) begin
            phase_q <= PH_HIGH;
            cpu_q   <= 1'b1;
        end else begin
            phase_q <= phase_step(phase_q);
            cpu_q   <= (phase_step(phase_q) == PH_HIGH);
        end
    end

    // Enable for logic that acts on the next processor-clock rising edge.
    always_comb begin
        clk_o.cpu     = cpu_q;
        clk_o.rise_en = (phase_q == PH_LOW_B) && !por;
    end
endmodule

// File: rtl/cgen_sync.sv
module cgen_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else if (en) begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cgen_rdy_qual.sv
module cgen_rdy_qual
    import cgen_pkg::*;
#(
    parameter int NUM_PAIRS = 2
) (
    input  logic [NUM_PAIRS-1:0] rdy_in,
    input  logic [NUM_PAIRS-1:0] rdy_en_n,
    output logic                 req
);
    logic [NUM_PAIRS-1:0] grant;

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        rdy_pair_t pair;
        assign pair.rdy  = rdy_in[i];
        assign pair.en_n = rdy_en_n[i];
        assign grant[i]  = pair_grants(pair);
    end

    assign req = |grant;
endmodule

// File: rtl/cgen_top.sv
module cgen_top
    import cgen_pkg::*;
#(
    parameter int NUM_PAIRS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 osc_clk,
    input  logic                 por,
    input  logic [NUM_PAIRS-1:0] rdy_in,
    input  logic [NUM_PAIRS-1:0] rdy_en_n,
    input  logic                 rst_req_n,
    output logic                 cpu_clk,
    output logic                 osc_out,
    output logic                 per_clk,
    output logic                 ready,
    output logic                 rst_out
);
    cpu_clk_t div_o;
    logic     rdy_req;
    logic     per_q;

    cgen_div3 u_div (
        .osc_clk (osc_clk),
        .por     (por),
        .clk_o   (div_o)
    );

    // Peripheral clock: toggles at each processor-clock rising edge.
    always_ff @(posedge osc_clk) begin
        if (por)               per_q <= 1'b0;
        else if (div_o.rise_en) per_q <= ~per_q;
    end

    cgen_rdy_qual #(.NUM_PAIRS(NUM_PAIRS)) u_qual (
        .rdy_in   (rdy_in),
        .rdy_en_n (rdy_en_n),
        .req      (rdy_req)
    );

    cgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
        .clk (osc_clk),
        .rst (por),
        .en  (div_o.rise_en),
        .d   (rdy_req),
        .q   (ready)
    );

    cgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
        .clk (osc_clk),
        .rst (por),
        .en  (div_o.rise_en),
        .d   (~rst_req_n),
        .q   (rst_out)
    );

    assign cpu_clk = div_o.cpu;
    assign per_clk = per_q;
    assign osc_out = osc_clk;
endmodule

// File: rtl/cgen_chk.sv
module cgen_chk (
    input logic osc_clk,
    input logic por,
    input logic cpu_clk,
    input logic per_clk,
    input logic ready,
    input logic rst_out
);
    // R2: high phase lasts one oscillator cycle
    p_high_one_r2: assert property (@(posedge osc_clk) disable iff (por)
        cpu_clk |=> !cpu_clk);

    // R2: after falling, stays low for a second cycle
    p_low_two_r2: assert property (@(posedge osc_clk) disable iff (por)
        $fell(cpu_clk) |=> !cpu_clk);

    // R1: two low cycles are followed by a high one
    p_period_r1: assert property (@(posedge osc_clk) disable iff (por)
        (!cpu_clk && $past(!cpu_clk)) |=> cpu_clk);

    // R5: peripheral clock changes only with processor rising edge
    p_per_edge_r5: assert property (@(posedge osc_clk) disable iff (por)
        !$rose(cpu_clk) |-> $stable(per_clk));

    p_per_toggle_r5: assert property (@(posedge osc_clk) disable iff (por)
        $rose(cpu_clk) |-> (per_clk != $past(per_clk)));

    // R7: ready moves only at processor rising edge
    p_ready_edge_r7: assert property (@(posedge osc_clk) disable iff (por)
        !$rose(cpu_clk) |-> $stable(ready));

    // R8: reset output moves only at processor rising edge
    p_rst_edge_r8: assert property (@(posedge osc_clk) disable iff (por)
        !$rose(cpu_clk) |-> $stable(rst_out));
endmodule

bind cgen_top cgen_chk u_chk (
    .osc_clk (osc_clk),
    .por     (por),
    .cpu_clk (cpu_clk),
    .per_clk (per_clk),
    .ready   (ready),
    .rst_out (rst_out)
);

// File: tb/cgen_top_tb.sv
`timescale 1ns/1ps
module cgen_top_tb;
    logic       osc_clk = 1'b0;
    logic       por = 1'b1;
    logic [1:0] rdy_in = 2'b00;
    logic [1:0] rdy_en_n = 2'b11;
    logic       rst_req_n = 1'b1;
    logic       cpu_clk, osc_out, per_clk, ready, rst_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 osc_clk = ~osc_clk;

    cgen_top u_dut (
        .osc_clk (osc_clk), .por (por), .rdy_in (rdy_in),
        .rdy_en_n (rdy_en_n), .rst_req_n (rst_req_n),
        .cpu_clk (cpu_clk), .osc_out (osc_out), .per_clk (per_clk),
        .ready (ready), .rst_out (rst_out)
    );

    // {en_n[1], en_n[0], rdy[1], rdy[0], expected ready}
    localparam logic [4:0] VEC [8] = '{
        5'b11_11_0, 5'b10_01_1, 5'b10_10_0, 5'b01_10_1,
        5'b01_01_0, 5'b00_00_0, 5'b00_10_1, 5'b00_11_1
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wait_cpu_rise();
        do begin
            @(posedge osc_clk);
            #1;
        end while (!cpu_clk);
    endtask

    function automatic logic model_ready(input logic [1:0] en_n, input logic [1:0] r);
        return |(r & ~en_n);
    endfunction

    initial begin
        logic prev;
        logic p0;
        repeat (3) @(posedge osc_clk);
        #1;
        // R3: power-on state
        check("R3 cpu_clk in por", cpu_clk, 1'b1);
        check("R3 per_clk in por", per_clk, 1'b0);
        check("R3 ready in por", ready, 1'b0);
        check("R3 rst_out in por", rst_out, 1'b1);
        @(negedge osc_clk);
        por = 1'b0;
        // R1/R2/R3: cycle pattern after power-on
        for (int i = 0; i < 9; i++) begin
            @(posedge osc_clk);
            #1;
            check((i % 3 == 2) ? "R1 cpu_clk high" : "R2 cpu_clk low",
                  cpu_clk, (i % 3 == 2));
        end
        // R4: buffered oscillator
        @(posedge osc_clk); #1; check("R4 osc_out high", osc_out, 1'b1);
        @(negedge osc_clk); #1; check("R4 osc_out low", osc_out, 1'b0);
        // R8: reset releases after power-on with request high
        wait_cpu_rise(); wait_cpu_rise();
        check("R8 rst_out released", rst_out, 1'b0);
        // R5: per_clk alternates across processor edges
        wait_cpu_rise(); p0 = per_clk;
        for (int i = 0; i < 4; i++) begin
            wait_cpu_rise();
            check("R5 per_clk toggle", per_clk, ~p0);
            p0 = per_clk;
        end
        // R6/R7/R9: vector table
        prev = ready;
        check("R9 idle ready low", ready, 1'b0);
        for (int i = 0; i < 8; i++) begin
            logic e;
            rdy_en_n = VEC[i][4:3];
            rdy_in   = VEC[i][2:1];
            e = VEC[i][0];
            if (e !== model_ready(VEC[i][4:3], VEC[i][2:1])) begin
                errors++;
                $display("FAIL R6 table entry %0d: actual %0b expected %0b",
                         i, e, model_ready(VEC[i][4:3], VEC[i][2:1]));
            end
            wait_cpu_rise();
            check("R7 ready delayed", ready, prev);
            wait_cpu_rise();
            check((i == 0) ? "R9 ready all disabled" : "R6 ready qualified", ready, e);
            prev = e;
        end
        // R9: both disabled, ready inputs high
        rdy_en_n = 2'b11; rdy_in = 2'b11;
        wait_cpu_rise(); wait_cpu_rise();
        check("R9 disabled with rdy high", ready, 1'b0);
        // R8: reset request assert and release
        rst_req_n = 1'b0;
        wait_cpu_rise();
        check("R8 rst_out not yet", rst_out, 1'b0);
        wait_cpu_rise();
        check("R8 rst_out asserted", rst_out, 1'b1);
        rst_req_n = 1'b1;
        wait_cpu_rise();
        check("R8 rst_out held", rst_out, 1'b1);
        wait_cpu_rise();
        check("R8 rst_out released", rst_out, 1'b0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule